// File: doc/BRIEF.md
# Hot-Plug Detect Interrupt Unit

This block watches an external hot-plug-detect input, which may bounce and arrives with no relation to the local clock. It synchronises the input and passes it through a programmable glitch filter. Each real change of the filtered level sets a sticky event bit: one bit for a connect (rising) and one for a disconnect (falling). A level interrupt from a neighbouring core is passed through as a third status source. A single interrupt output is raised whenever an enabled source is active.

Software reaches the block through a small register port. The port has a write strobe, a word address, write data, and read data that is decoded combinationally. Through it software sets the filter, reads the raw status, acknowledges events by writing ones, and enables sources. The filtered plug level is available both as a port and as a read-only register.

Top module: `hpd_irq_unit`

## Requirements
- R1: After reset, the status register and the mask register read 0, and the filter configuration reads 0x0000A0A0. The level register and the `hpd_level` and `irq` outputs are 0.
- R2: The filter configuration sits at word address 0. Bits 15:12 hold N, the number of consecutive samples needed. Bits 7:0 hold P, the interval between samples in clock cycles. A value of 0 in either field acts as 1. The raw input passes through two synchronising flops. The filtered level takes the new value only after N consecutive samples agree with each other and differ from the current level. A shorter disturbance leaves the filtered level unchanged.
- R3: The level register at word address 4 reads 1 while the filtered level is high and 0 while it is low. Output `hpd_level` carries the same value.
- R4: Status sits at word address 1. Bit 1 becomes set and stays set on each rise of the filtered level. Bit 2 becomes set and stays set on each fall. Neither bit is set unless the filtered level actually changes.
- R5: Status bit 0 follows the `core_irq` input level directly.
- R6: A write to the clear register at word address 2 clears each status event bit whose write data bit is 1. Bits written as 0 keep their value. Writing back the value read from status therefore clears exactly those events. Writes to the status register have no effect.
- R7: If an edge event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: The mask at word address 3 uses the same bit positions as status, and a 1 enables that source. `irq` is the OR over all bits of status AND mask.
- R9: The clear register and addresses 5 to 7 read as 0. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hpd_raw | input | 1 | Unsynchronised hot-plug-detect input |
| core_irq | input | 1 | Pass-through core interrupt level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| hpd_level | output | 1 | Filtered plug level |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `hpd_raw` is only seen through the synchroniser. They also assume that register writes are single-cycle strobes whose address and data are stable across the sampling edge. Finally, they assume the filter settings do not change while a level flip is being judged. The bench drives every input a fixed delay after the falling edge, so each input is stable around the rising edge. The event-beats-clear property needs a clear to land exactly on a flip cycle. The bench forces this once with a one-cycle filter setting, and long randomised runs of hold lengths and clears produce more coincidences.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int CNT_W   = 4;
  localparam int CNT_LSB = 12;
  localparam int PRE_W   = 8;
  localparam int PRE_LSB = 0;
  localparam int NSRC    = 3;
  localparam int BIT_CORE = 0;
  localparam int BIT_RISE = 1;
  localparam int BIT_FALL = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 3'd0,
    A_STAT = 3'd1,
    A_CLR  = 3'd2,
    A_MASK = 3'd3,
    A_LVL  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_first
      assign src = d_i;
    end else begin : g_rest
      assign src = chain_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= src;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_glitch_filter.sv
module hpd_glitch_filter #(
  parameter int CNT_W = 4,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic [CNT_W-1:0] need_i,
  input  logic [PRE_W-1:0] interval_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [PRE_W-1:0] pre_q, pre_d, interval_eff;
  logic [CNT_W-1:0] run_q, run_d, need_eff;
  logic             level_q, level_d;
  logic             tick, flip;

  assign interval_eff = (interval_i == '0) ? PRE_W'(1) : interval_i;
  assign need_eff     = (need_i == '0) ? CNT_W'(1) : need_i;
  assign tick         = (pre_q >= interval_eff - PRE_W'(1));

  always_comb begin
    pre_d   = tick ? '0 : pre_q + PRE_W'(1);
    run_d   = run_q;
    level_d = level_q;
    flip    = 1'b0;
    if (tick) begin
      if (sample_i != level_q) begin
        if (({1'b0, run_q} + (CNT_W+1)'(1)) >= {1'b0, need_eff}) begin
          flip    = 1'b1;
          level_d = sample_i;
          run_d   = '0;
        end else begin
          run_d = run_q + CNT_W'(1);
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      run_q   <= '0;
      level_q <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      run_q   <= run_d;
      level_q <= level_d;
    end
  end

  assign level_o = level_q;
  assign rise_o  = flip & sample_i;
  assign fall_o  = flip & ~sample_i;

  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level_q));
  // R2
  level_takes_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> (level_q == $past(sample_i)));
endmodule

// File: rtl/hpd_irq_regs.sv
module hpd_irq_regs
  import hpd_irq_pkg::*;
#(
  parameter logic [CNT_W-1:0] CNT_RST = 4'hA,
  parameter logic [PRE_W-1:0] PRE_RST = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              core_i,
  input  logic              level_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic [CNT_W-1:0]  need_o,
  output logic [PRE_W-1:0]  interval_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] need_q, need_d;
  logic [PRE_W-1:0] interval_q, interval_d;
  logic [NSRC-1:0]  mask_q, mask_d;
  logic             rise_q, rise_d, fall_q, fall_d;
  logic             cfg_we, mask_we, clr_we;
  logic [NSRC-1:0]  status;

  assign cfg_we  = wr_i && (addr_i == A_CFG);
  assign mask_we = wr_i && (addr_i == A_MASK);
  assign clr_we  = wr_i && (addr_i == A_CLR);

  always_comb begin
    need_d     = need_q;
    interval_d = interval_q;
    mask_d     = mask_q;
    if (cfg_we) begin
      need_d     = wdata_i[CNT_LSB +: CNT_W];
      interval_d = wdata_i[PRE_LSB +: PRE_W];
    end
    if (mask_we) mask_d = wdata_i[NSRC-1:0];
    rise_d = (rise_q & ~(clr_we & wdata_i[BIT_RISE])) | rise_i;
    fall_d = (fall_q & ~(clr_we & wdata_i[BIT_FALL])) | fall_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q     <= CNT_RST;
      interval_q <= PRE_RST;
      mask_q     <= '0;
      rise_q     <= 1'b0;
      fall_q     <= 1'b0;
    end else begin
      need_q     <= need_d;
      interval_q <= interval_d;
      mask_q     <= mask_d;
      rise_q     <= rise_d;
      fall_q     <= fall_d;
    end
  end

  always_comb begin
    status           = '0;
    status[BIT_CORE] = core_i;
    status[BIT_RISE] = rise_q;
    status[BIT_FALL] = fall_q;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CFG: begin
        rdata_o[CNT_LSB +: CNT_W] = need_q;
        rdata_o[PRE_LSB +: PRE_W] = interval_q;
      end
      A_STAT:  rdata_o[NSRC-1:0] = status;
      A_MASK:  rdata_o[NSRC-1:0] = mask_q;
      A_LVL:   rdata_o[0]        = level_i;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o      = |(status & mask_q);
  assign need_o     = need_q;
  assign interval_o = interval_q;

  // R4
  rise_needs_level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rise_q) |-> $rose(level_i));
  // R4
  fall_needs_level_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fall_q) |-> $fell(level_i));
  // R7
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && clr_we && wdata_i[BIT_RISE]) |=> rise_q);
  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata_i[BIT_FALL] && !fall_i) |=> !fall_q);
  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CNT_RST     = 4'hA,
  parameter logic [PRE_W-1:0] PRE_RST     = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hpd_raw,
  input  logic              core_irq,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              hpd_level,
  output logic              irq
);
  logic             hpd_sync_s;
  logic             rise_s, fall_s;
  logic [CNT_W-1:0] need_s;
  logic [PRE_W-1:0] interval_s;

  hpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(hpd_raw), .q_o(hpd_sync_s)
  );

  hpd_glitch_filter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .sample_i(hpd_sync_s),
    .need_i(need_s), .interval_i(interval_s),
    .level_o(hpd_level), .rise_o(rise_s), .fall_o(fall_s)
  );

  hpd_irq_regs #(.CNT_RST(CNT_RST), .PRE_RST(PRE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .core_i(core_irq),
    .level_i(hpd_level), .rise_i(rise_s), .fall_i(fall_s),
    .need_o(need_s), .interval_o(interval_s), .irq_o(irq)
  );
endmodule

// File: tb/tb_hpd_irq_unit.sv
module tb_hpd_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hpd_raw = 1'b0;
  logic        core_irq = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        hpd_level;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit live = 1'b0;

  // behavioural reference state
  int m_s1, m_s2, m_pre, m_run, m_lvl, m_rise, m_fall, m_need, m_int, m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .hpd_raw(hpd_raw), .core_irq(core_irq),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .hpd_level(hpd_level), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h time=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return 32'((m_need << 12) | m_int);
      3'd1: return 32'((m_fall << 2) | (m_rise << 1) | int'(core_irq));
      3'd3: return 32'(m_mask);
      3'd4: return 32'(m_lvl);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    return ((m_mask & 1) != 0 && core_irq) || ((m_mask & 2) != 0 && m_rise != 0)
        || ((m_mask & 4) != 0 && m_fall != 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int ie, ne, nlvl, flip;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_pre = 0; m_run = 0; m_lvl = 0;
      m_rise = 0; m_fall = 0; m_need = 10; m_int = 160; m_mask = 0;
    end else begin
      ie = (m_int == 0) ? 1 : m_int;
      ne = (m_need == 0) ? 1 : m_need;
      flip = 0; nlvl = m_lvl;
      if (m_pre >= ie - 1) begin
        m_pre = 0;
        if (m_s2 != m_lvl) begin
          if (m_run + 1 >= ne) begin flip = 1; nlvl = m_s2; m_run = 0; end
          else m_run = m_run + 1;
        end else m_run = 0;
      end else m_pre = m_pre + 1;
      if (reg_wr && reg_addr == 3'd2) begin
        if (reg_wdata[1]) m_rise = 0;
        if (reg_wdata[2]) m_fall = 0;
      end
      if (flip != 0 && nlvl == 1) m_rise = 1;
      if (flip != 0 && nlvl == 0) m_fall = 1;
      m_lvl = nlvl;
      if (reg_wr && reg_addr == 3'd0) begin
        m_need = int'(reg_wdata[15:12]);
        m_int  = int'(reg_wdata[7:0]);
      end
      if (reg_wr && reg_addr == 3'd3) m_mask = int'(reg_wdata[2:0]);
      m_s2 = m_s1;
      m_s1 = int'(hpd_raw);
    end
  end

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk({31'd0, hpd_level}, 32'(m_lvl), "R3 level port");
      chk({31'd0, irq}, {31'd0, m_irq()}, "R8 irq");
      case (reg_addr)
        3'd0: chk(reg_rdata, m_read(reg_addr), "R2 cfg read");
        3'd1: chk(reg_rdata, m_read(reg_addr), "R4 R5 R6 R7 status read");
        3'd3: chk(reg_rdata, m_read(reg_addr), "R8 mask read");
        3'd4: chk(reg_rdata, m_read(reg_addr), "R3 level read");
        default: chk(reg_rdata, m_read(reg_addr), "R9 other read");
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    reg_wr = w; reg_addr = a; reg_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd1, 32'd0);
  endtask

  initial begin
    int r;
    void'($urandom(32'h5eed));
    idle(3);
    @(negedge clk); #2; rst_n = 1'b1;
    live = 1'b1;
    // R1 reset values
    step(0, 3'd0, 0); #1 chk(reg_rdata, 32'h0000A0A0, "R1 cfg reset");
    step(0, 3'd1, 0); #1 chk(reg_rdata, 32'd0, "R1 status reset");
    step(0, 3'd3, 0); #1 chk(reg_rdata, 32'd0, "R1 mask reset");
    step(0, 3'd4, 0); #1 chk(reg_rdata, 32'd0, "R1 level reset");
    chk({31'd0, irq}, 32'd0, "R1 irq reset");

    // R7: clear lands on the rise cycle with N=1, P=1
    step(1, 3'd0, 32'h1001);
    step(1, 3'd3, 32'h7);
    idle(3);
    step(0, 3'd1, 0); hpd_raw = 1'b1;
    step(0, 3'd1, 0);
    step(1, 3'd2, 32'h2);
    step(0, 3'd1, 0); #1;
    chk(reg_rdata & 32'h2, 32'h2, "R7 event wins over clear");
    chk({31'd0, irq}, 32'd1, "R8 irq on enabled rise");
    // R6: write back read value
    step(1, 3'd2, 32'h6);
    step(0, 3'd1, 0); #1 chk(reg_rdata, 32'd0, "R6 clear by write back");

    // R5: core pass-through
    core_irq = 1'b1;
    step(0, 3'd1, 0); #1 chk(reg_rdata, 32'd1, "R5 core bit");
    chk({31'd0, irq}, 32'd1, "R5 core irq");
    step(1, 3'd3, 32'h6); core_irq = 1'b1;
    step(0, 3'd1, 0); #1 chk({31'd0, irq}, 32'd0, "R8 core masked");
    core_irq = 1'b0;

    // R2: short glitch with N=3, P=2 is rejected
    step(1, 3'd0, 32'h3002);
    idle(4);
    hpd_raw = 1'b0; idle(3); hpd_raw = 1'b1;
    idle(12); #1;
    chk({31'd0, hpd_level}, 32'd1, "R2 glitch rejected");
    step(0, 3'd1, 0); #1 chk(reg_rdata & 32'h4, 32'd0, "R4 no fall on glitch");
    hpd_raw = 1'b0; idle(14);
    step(0, 3'd4, 0); #1 chk(reg_rdata, 32'd0, "R3 level low after hold");
    step(0, 3'd1, 0); #1 chk(reg_rdata & 32'h4, 32'h4, "R4 fall sticky");

    // R6 and R9: ignored writes
    step(1, 3'd1, 32'h0);
    step(1, 3'd5, 32'hFFFF_FFFF);
    step(1, 3'd7, 32'hFFFF_FFFF);
    step(0, 3'd1, 0); #1 chk(reg_rdata & 32'h4, 32'h4, "R6 status write ignored");
    step(0, 3'd6, 0); #1 chk(reg_rdata, 32'd0, "R9 unmapped reads zero");

    // default filter setting, long hold
    step(1, 3'd0, 32'hA0A0);
    hpd_raw = 1'b1; idle(1700);
    step(0, 3'd4, 0); #1 chk(reg_rdata, 32'd1, "R2 default filter settles");

    // randomised traffic, compared every clock
    step(1, 3'd0, 32'h2001);
    for (int i = 0; i < 30000; i++) begin
      r = int'($urandom % 100);
      if (r < 8) begin
        logic [2:0] a = 3'($urandom % 8);
        logic [31:0] d = $urandom;
        if (a == 3'd0) d = {16'd0, 4'($urandom % 5), 4'd0, 8'($urandom % 4)};
        step(1, a, d);
      end else if (r < 14) begin
        step(1, 3'd2, {29'd0, 3'($urandom)});
      end else begin
        step(0, 3'($urandom % 8), 32'd0);
      end
      if ($urandom % 6 == 0) hpd_raw = ~hpd_raw;
      if ($urandom % 20 == 0) core_irq = ~core_irq;
    end
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule